// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps calendar time in packed BCD: seconds, minutes, 24-hour hours, a day-of-week counter, date, month and a two-digit year. A one-cycle `tick` pulse, supplied once per second by logic outside the block, advances the count. The block handles the length of each month, including February in leap years.

The host sees the clock as eight byte registers in the top eight addresses of a 15-bit byte address space, 0x7FF8 to 0x7FFF. Access is through a synchronous memory-style port. One set of counters advances on every tick. A second, host-visible copy follows those counters, except while the host holds the freeze bit in the control byte. While that bit is set, the visible copy keeps the time that was current when the freeze was written. Clearing the bit reloads every visible field together.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Register offsets from base 0x7FF8 are: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. A synchronous active-high `rst` sets the time to 00:00:00, day of week 01, date 01, month 01, year 00, and clears control to 0x00.
- R2: Seconds and minutes count 00 to 59 in packed BCD, including the digit carry 09 to 10. Each rolls over from 59 to 00 and carries into the next field.
- R3: Hours count 00 to 23. A rollover from 23 to 00 advances both the date and the day of week.
- R4: Day of week counts 01 to 07 and wraps from 07 to 01 at midnight.
- R5: After the last day of the month, the date returns to 01 and the month advances. Months 04, 06, 09 and 11 have 30 days. All other months except 02 have 31 days.
- R6: February has 29 days when the two BCD year digits form a number divisible by 4, and 28 days otherwise.
- R7: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R8: While control bit 6 (freeze) is 1, reads of offsets 1 to 7 return the time that was current when the bit was written. Ticks keep advancing the internal count during the freeze.
- R9: When the freeze bit is cleared, all seven visible fields reload from the internal count on the same clock edge, one cycle after the write. Control reads back bit 6 only; its other bits read 0.
- R10: A write with `cs` and `we` high to offsets 1 to 7 loads that internal field; the visible copy follows when it is not frozen. Writes with `cs` low, and writes below 0x7FF8, change nothing.
- R11: A read with `cs` high and `we` low presents the addressed byte on `rdata` one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| cs | input | 1 | Chip select for read and write |
| we | input | 1 | Write enable (1 write, 0 read) |
| addr | input | 15 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |

## Verification
The range assertions assume that the host writes only valid packed BCD that fits each field. For example, it writes day of week 1 to 7 and dates that exist in the month. The stimulus writes only legal calendar values.

The counter-hold and counter-advance assertions assume that a tick never coincides with a host write. The bench drives ticks in their own cycles, apart from every write.

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int OFS_W = $clog2(NREG);
  localparam logic [ADDR_W-OFS_W-1:0] WIN_TAG = '1;
  localparam int FREEZE_BIT = 6;

  logic [7:0] s_q, m_q, h_q, w_q, d_q, mo_q, y_q;
  logic [55:0] vis_q;
  logic        halt_q;

  logic [OFS_W-1:0] ofs;
  logic in_win, wr, rd;
  assign ofs    = addr[OFS_W-1:0];
  assign in_win = (addr[ADDR_W-1:OFS_W] == WIN_TAG);
  assign wr     = cs && we && in_win;
  assign rd     = cs && !we && in_win;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic leap;
  logic [7:0] last_day;
  assign leap = (!y_q[4] && (y_q[3:0] == 4'd0 || y_q[3:0] == 4'd4 || y_q[3:0] == 4'd8)) ||
                ( y_q[4] && (y_q[3:0] == 4'd2 || y_q[3:0] == 4'd6));

  always_comb begin
    case (mo_q)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  logic c_s, c_m, c_h, c_d, c_mo;
  assign c_s  = tick && (s_q == 8'h59);
  assign c_m  = c_s  && (m_q == 8'h59);
  assign c_h  = c_m  && (h_q == 8'h23);
  assign c_d  = c_h  && (d_q == last_day);
  assign c_mo = c_d  && (mo_q == 8'h12);

  logic [7:0] s_n, m_n, h_n, w_n, d_n, mo_n, y_n;
  assign s_n  = !tick ? s_q  : (c_s  ? 8'h00 : bcd_inc(s_q));
  assign m_n  = !c_s  ? m_q  : (c_m  ? 8'h00 : bcd_inc(m_q));
  assign h_n  = !c_m  ? h_q  : (c_h  ? 8'h00 : bcd_inc(h_q));
  assign w_n  = !c_h  ? w_q  : ((w_q == 8'h07) ? 8'h01 : w_q + 8'd1);
  assign d_n  = !c_h  ? d_q  : (c_d  ? 8'h01 : bcd_inc(d_q));
  assign mo_n = !c_d  ? mo_q : (c_mo ? 8'h01 : bcd_inc(mo_q));
  assign y_n  = !c_mo ? y_q  : ((y_q == 8'h99) ? 8'h00 : bcd_inc(y_q));

  logic [55:0] tv;
  assign tv = {y_q, mo_q, d_q, w_q, h_q, m_q, s_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      {y_q, mo_q, d_q, w_q, h_q, m_q, s_q} <= {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      vis_q  <= {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      halt_q <= 1'b0;
    end else begin
      s_q    <= (wr && ofs == 3'd1) ? wdata : s_n;
      m_q    <= (wr && ofs == 3'd2) ? wdata : m_n;
      h_q    <= (wr && ofs == 3'd3) ? wdata : h_n;
      w_q    <= (wr && ofs == 3'd4) ? wdata : w_n;
      d_q    <= (wr && ofs == 3'd5) ? wdata : d_n;
      mo_q   <= (wr && ofs == 3'd6) ? wdata : mo_n;
      y_q    <= (wr && ofs == 3'd7) ? wdata : y_n;
      halt_q <= (wr && ofs == 3'd0) ? wdata[FREEZE_BIT] : halt_q;
      if (!halt_q) vis_q <= tv;
    end
  end

  logic [7:0] rsel;
  always_comb begin
    case (ofs)
      3'd0:    rsel = 8'(halt_q) << FREEZE_BIT;
      3'd1:    rsel = vis_q[7:0];
      3'd2:    rsel = vis_q[15:8];
      3'd3:    rsel = vis_q[23:16];
      3'd4:    rsel = vis_q[31:24];
      3'd5:    rsel = vis_q[39:32];
      3'd6:    rsel = vis_q[47:40];
      default: rsel = vis_q[55:48];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd ? rsel : '0;
  end

  assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> $stable(vis_q));
  assert_reload_R9: assert property (@(posedge clk) disable iff (rst)
    !halt_q |=> (vis_q == $past(tv)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable(tv));
  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr) |=> (s_q != $past(s_q)));
  assert_sec_range_R2: assert property (@(posedge clk) disable iff (rst)
    (s_q <= 8'h59) && (m_q <= 8'h59));
  assert_hour_range_R3: assert property (@(posedge clk) disable iff (rst)
    h_q <= 8'h23);
  assert_dow_range_R4: assert property (@(posedge clk) disable iff (rst)
    (w_q >= 8'h01) && (w_q <= 8'h07));
  assert_date_range_R5: assert property (@(posedge clk) disable iff (rst)
    (d_q >= 8'h01) && (d_q <= 8'h31));
endmodule

// File: tb/bcd_calendar_clock_tb.sv
module bcd_calendar_clock_tb_top;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, cs = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bcd_calendar_clock dut_i (.clk(clk), .rst(rst), .tick(tick), .cs(cs), .we(we),
                            .addr(addr), .wdata(wdata), .rdata(rdata));

  // each entry: {y,mo,d,h,mi,s,dow} before one tick, then expected after it
  localparam logic [111:0] VEC [16] = '{
    {56'h00010100000001, 56'h00010100000101},
    {56'h23031510205903, 56'h23031510210003},
    {56'h23031510595903, 56'h23031511000003},
    {56'h23031523595903, 56'h23031600000004},
    {56'h23033123595907, 56'h23040100000001},
    {56'h23043023595902, 56'h23050100000003},
    {56'h24022823595903, 56'h24022900000004},
    {56'h24022923595904, 56'h24030100000005},
    {56'h23022823595902, 56'h23030100000003},
    {56'h23123123595907, 56'h24010100000001},
    {56'h99123123595905, 56'h00010100000006},
    {56'h00022823595901, 56'h00022900000002},
    {56'h19093023595903, 56'h19100100000004},
    {56'h12022823595901, 56'h12022900000002},
    {56'h10022823595901, 56'h10030100000002},
    {56'h23060912340906, 56'h23060912341006}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr_at(input logic [14:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk); cs = sel; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic wr_reg(input int ofs, input logic [7:0] d);
    wr_at(15'h7FF8 + 15'(ofs), d, 1'b1);
  endtask

  task automatic rd_at(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); d = rdata; cs = 1'b0;
  endtask

  task automatic rd_reg(input int ofs, output logic [7:0] d);
    rd_at(15'h7FF8 + 15'(ofs), d);
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values, R11 read path
    rd_reg(0, v); check("R1 ctrl", v, 8'h00);
    rd_reg(1, v); check("R1 sec", v, 8'h00);
    rd_reg(2, v); check("R1 min", v, 8'h00);
    rd_reg(3, v); check("R1 hour", v, 8'h00);
    rd_reg(4, v); check("R1 dow", v, 8'h01);
    rd_reg(5, v); check("R1 date", v, 8'h01);
    rd_reg(6, v); check("R1 month", v, 8'h01);
    rd_reg(7, v); check("R11 year", v, 8'h00);

    // R2..R7 table walk
    for (int i = 0; i < 16; i++) begin
      logic [55:0] a, b;
      a = VEC[i][111:56];
      b = VEC[i][55:0];
      wr_reg(7, a[55:48]); wr_reg(6, a[47:40]); wr_reg(5, a[39:32]);
      wr_reg(3, a[31:24]); wr_reg(2, a[23:16]); wr_reg(1, a[15:8]);
      wr_reg(4, a[7:0]);
      pulse();
      rd_reg(7, v); check($sformatf("R7 year vec%0d", i), v, b[55:48]);
      rd_reg(6, v); check($sformatf("R5 month vec%0d", i), v, b[47:40]);
      rd_reg(5, v); check($sformatf("R6 date vec%0d", i), v, b[39:32]);
      rd_reg(3, v); check($sformatf("R3 hour vec%0d", i), v, b[31:24]);
      rd_reg(2, v); check($sformatf("R2 min vec%0d", i), v, b[23:16]);
      rd_reg(1, v); check($sformatf("R2 sec vec%0d", i), v, b[15:8]);
      rd_reg(4, v); check($sformatf("R4 dow vec%0d", i), v, b[7:0]);
    end

    // R8 freeze while internal count runs; R9 control readback and reload
    wr_reg(3, 8'h10); wr_reg(2, 8'h20); wr_reg(1, 8'h30);
    @(negedge clk);
    wr_reg(0, 8'h40);
    pulse(); pulse(); pulse();
    rd_reg(1, v); check("R8 frozen sec", v, 8'h30);
    rd_reg(0, v); check("R9 ctrl set", v, 8'h40);
    wr_reg(0, 8'hBF);
    @(negedge clk);
    rd_reg(0, v); check("R9 ctrl clear", v, 8'h00);
    rd_reg(1, v); check("R8 counted during freeze", v, 8'h33);

    // R9 full reload after a frozen year rollover
    wr_reg(7, 8'h99); wr_reg(6, 8'h12); wr_reg(5, 8'h31); wr_reg(4, 8'h07);
    wr_reg(3, 8'h23); wr_reg(2, 8'h59); wr_reg(1, 8'h58);
    @(negedge clk);
    wr_reg(0, 8'h40);
    pulse(); pulse();
    rd_reg(3, v); check("R8 frozen hour", v, 8'h23);
    rd_reg(7, v); check("R8 frozen year", v, 8'h99);
    wr_reg(0, 8'h00);
    @(negedge clk);
    rd_reg(1, v); check("R9 reload sec", v, 8'h00);
    rd_reg(2, v); check("R9 reload min", v, 8'h00);
    rd_reg(3, v); check("R9 reload hour", v, 8'h00);
    rd_reg(4, v); check("R9 reload dow", v, 8'h01);
    rd_reg(5, v); check("R9 reload date", v, 8'h01);
    rd_reg(6, v); check("R9 reload month", v, 8'h01);
    rd_reg(7, v); check("R9 reload year", v, 8'h00);

    // R10 gating and out-of-window writes
    wr_reg(1, 8'h45);
    wr_at(15'h7FF1, 8'h11, 1'b1);
    wr_at(15'h7FF9, 8'h12, 1'b0);
    wr_at(15'h7FF8, 8'h40, 1'b0);
    rd_at(15'h0000, v);
    rd_reg(1, v); check("R10 sec untouched", v, 8'h45);
    rd_reg(0, v); check("R10 ctrl untouched", v, 8'h00);

    // R10 write while frozen shows after release
    wr_reg(0, 8'h40);
    wr_reg(1, 8'h10);
    @(negedge clk);
    rd_reg(1, v); check("R10 frozen hides write", v, 8'h45);
    wr_reg(0, 8'h00);
    @(negedge clk);
    rd_reg(1, v); check("R10 write visible", v, 8'h10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule